// File: doc/BRIEF.md
# Compare-Value Timer Channel

This block is a single deadline timer. It watches a shared 64-bit system count, subtracts a per-channel offset to form the channel count, and drives a level interrupt once that channel count has caught up with a programmed compare value. The offset is a register in the virtual variant. In the physical variant it is tied to zero.

Software can set the deadline in two ways. It can write a 64-bit absolute compare value, or it can write a signed 32-bit countdown that is added to the current channel count. The same countdown view can be read back at any time as the low 32 bits of the remaining distance. A small control register holds an enable bit and a mask bit, and it shows the comparison result as a read-only status bit.

The block is driven by plain write strobes, one for each register. Address decoding is left to the surrounding logic. The interrupt output is a flop.

Top module: `tmr_chan`

## Requirements
- R1: After reset, enable and mask are 0, the compare value is 0, the offset is 0 and `irq` is 0.
- R2: `chan_count` always equals `sys_count - off_rd` modulo 2^64. When VIRTUAL=0, `off_rd` stays 0 and offset writes have no effect.
- R3: The status bit is 1 exactly when `chan_count >= cmp_rd`, using an unsigned 64-bit compare. Equality counts as met.
- R4: A pulse on `cmp_wr` loads `cmp_wdata` into the compare value at that clock edge.
- R5: A pulse on `rel_wr` loads the compare value with `chan_count` plus `rel_wdata` sign-extended from 32 bits. If `cmp_wr` is high in the same cycle, the absolute write wins.
- R6: `rel_rd` equals the low 32 bits of the compare value minus the low 32 bits of `chan_count`.
- R7: Control field positions are: bit 0 enable, bit 1 mask, bit 2 status. `ctl_wr` loads bits 0 and 1 from `ctl_wdata`. The value written to bit 2 is ignored.
- R8: `irq` is registered. On each clock edge it takes the value of (enable AND NOT mask AND status), so it changes one cycle after the state it reflects.
- R9: If the condition is met, clearing the mask or setting the enable raises `irq` two edges after the write strobe is sampled. Setting the mask or clearing the enable drops `irq` two edges after the write.
- R10: A change of the system count moves `irq` one edge later. A write of the compare value, the countdown or the offset re-evaluates the condition, and `irq` follows two edges after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | CNT_W | Shared system count |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control write data (bit 0 enable, bit 1 mask, bit 2 ignored) |
| cmp_wr | input | 1 | Absolute compare write strobe |
| cmp_wdata | input | CNT_W | Absolute compare write data |
| rel_wr | input | 1 | Relative countdown write strobe |
| rel_wdata | input | REL_W | Signed countdown write data |
| off_wr | input | 1 | Offset write strobe |
| off_wdata | input | CNT_W | Offset write data |
| ctl_rd | output | 3 | Control view {status, mask, enable} |
| cmp_rd | output | CNT_W | Compare value |
| rel_rd | output | REL_W | Countdown view |
| off_rd | output | CNT_W | Current offset |
| chan_count | output | CNT_W | System count minus offset |
| irq | output | 1 | Level interrupt, registered |

## Verification
On every cycle, the checker confirms several relations:
- the channel count matches the system count minus the offset;
- the status bit agrees with an unsigned compare of the visible count and compare value;
- each write strobe lands its value one edge later, with the absolute write winning a collision;
- the interrupt equals the previous cycle's enable, mask and status.

Only the bench's scenarios can show the rest:
- the exact two-edge latency from a mask or enable write to the interrupt;
- the sign extension of negative countdown writes;
- wrap-around of a negative countdown read;
- that the written status bit and offset writes on the physical variant are ignored.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int CTL_W        = 3;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;

  typedef struct packed {
    logic mask;
    logic en;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_offset.sv
module tmr_offset #(
  parameter int CNT_W   = 64,
  parameter bit VIRTUAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             off_wr,
  input  logic [CNT_W-1:0] off_wdata,
  output logic [CNT_W-1:0] off_q
);
  generate
    if (VIRTUAL) begin : g_virt
      logic [CNT_W-1:0] off_r;
      always_ff @(posedge clk) begin
        if (rst)         off_r <= '0;
        else if (off_wr) off_r <= off_wdata;
      end
      assign off_q = off_r;
    end else begin : g_phys
      logic unused_off;
      assign unused_off = clk ^ rst ^ off_wr ^ (^off_wdata);
      assign off_q = '0;
    end
  endgenerate
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 64,
  parameter int REL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             rel_wr,
  input  logic [REL_W-1:0] rel_wdata,
  output logic [CNT_W-1:0] cmp_q,
  output logic [REL_W-1:0] rel_view,
  output logic             cond
);
  localparam int EXT_W = CNT_W - REL_W;

  logic [CNT_W-1:0] rel_ext;
  logic [CNT_W-1:0] cmp_r;

  assign rel_ext = {{EXT_W{rel_wdata[REL_W-1]}}, rel_wdata};

  always_ff @(posedge clk) begin
    if (rst)         cmp_r <= '0;
    else if (cmp_wr) cmp_r <= cmp_wdata;
    else if (rel_wr) cmp_r <= count + rel_ext;
  end

  assign cmp_q    = cmp_r;
  assign cond     = (count >= cmp_r);
  assign rel_view = cmp_r[REL_W-1:0] - count[REL_W-1:0];
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cond,
  output logic [CTL_W-1:0] ctl_view,
  output logic             irq
);
  tmr_ctl_t ctl_r;
  logic     irq_r;
  logic     unused_stat_wr;

  assign unused_stat_wr = ctl_wdata[CTL_STAT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= '0;
    end else if (ctl_wr) begin
      ctl_r.en   <= ctl_wdata[CTL_EN_BIT];
      ctl_r.mask <= ctl_wdata[CTL_MASK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_r <= 1'b0;
    else     irq_r <= ctl_r.en & ~ctl_r.mask & cond;
  end

  always_comb begin
    ctl_view               = '0;
    ctl_view[CTL_EN_BIT]   = ctl_r.en;
    ctl_view[CTL_MASK_BIT] = ctl_r.mask;
    ctl_view[CTL_STAT_BIT] = cond;
  end

  assign irq = irq_r;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int REL_W   = 32,
  parameter bit VIRTUAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] sys_count,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             rel_wr,
  input  logic [REL_W-1:0] rel_wdata,
  input  logic             off_wr,
  input  logic [CNT_W-1:0] off_wdata,
  output logic [CTL_W-1:0] ctl_rd,
  output logic [CNT_W-1:0] cmp_rd,
  output logic [REL_W-1:0] rel_rd,
  output logic [CNT_W-1:0] off_rd,
  output logic [CNT_W-1:0] chan_count,
  output logic             irq
);
  logic [CNT_W-1:0] off_q;
  logic             cond;

  tmr_offset #(.CNT_W(CNT_W), .VIRTUAL(VIRTUAL)) u_off (
    .clk(clk), .rst(rst), .off_wr(off_wr), .off_wdata(off_wdata), .off_q(off_q)
  );

  assign chan_count = sys_count - off_q;
  assign off_rd     = off_q;

  tmr_compare #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cmp (
    .clk(clk), .rst(rst), .count(chan_count),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .rel_wr(rel_wr), .rel_wdata(rel_wdata),
    .cmp_q(cmp_rd), .rel_view(rel_rd), .cond(cond)
  );

  tmr_ctl u_ctl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cond(cond), .ctl_view(ctl_rd), .irq(irq)
  );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int REL_W   = 32,
  parameter bit VIRTUAL = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] sys_count,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic             cmp_wr,
  input logic [CNT_W-1:0] cmp_wdata,
  input logic             rel_wr,
  input logic [REL_W-1:0] rel_wdata,
  input logic [CTL_W-1:0] ctl_rd,
  input logic [CNT_W-1:0] cmp_rd,
  input logic [CNT_W-1:0] off_rd,
  input logic [CNT_W-1:0] chan_count,
  input logic             irq
);
  localparam int EXT_W = CNT_W - REL_W;

  // R1: reset state seen on the cycle after a reset edge
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && cmp_rd == '0 && off_rd == '0 &&
             ctl_rd[CTL_EN_BIT] == 1'b0 && ctl_rd[CTL_MASK_BIT] == 1'b0));

  a_r2_count_offset: assert property (@(posedge clk) disable iff (rst)
    chan_count == sys_count - off_rd);

  a_r2_phys_zero: assert property (@(posedge clk) disable iff (rst)
    !VIRTUAL |-> off_rd == '0);

  a_r3_status: assert property (@(posedge clk) disable iff (rst)
    ctl_rd[CTL_STAT_BIT] == (chan_count >= cmp_rd));

  a_r4_abs_write: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> cmp_rd == $past(cmp_wdata));

  a_r5_rel_write: assert property (@(posedge clk) disable iff (rst)
    (rel_wr && !cmp_wr) |=>
      cmp_rd == $past(chan_count + {{EXT_W{rel_wdata[REL_W-1]}}, rel_wdata}));

  a_r7_ctl_write: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ctl_rd[CTL_EN_BIT] == $past(ctl_wdata[CTL_EN_BIT]) &&
                ctl_rd[CTL_MASK_BIT] == $past(ctl_wdata[CTL_MASK_BIT])));

  a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(ctl_rd[CTL_EN_BIT] & ~ctl_rd[CTL_MASK_BIT] &
                                 ctl_rd[CTL_STAT_BIT]));

  a_r9_mask_drop: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[CTL_MASK_BIT]) |=> ##1 !irq);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .REL_W(REL_W), .VIRTUAL(VIRTUAL)) u_chk (
  .clk(clk), .rst(rst), .sys_count(sys_count), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
  .rel_wr(rel_wr), .rel_wdata(rel_wdata), .ctl_rd(ctl_rd), .cmp_rd(cmp_rd),
  .off_rd(off_rd), .chan_count(chan_count), .irq(irq)
);

// File: tb/test_tmr_chan.sv
module test_tmr_chan;
  localparam int CNT_W = 64;
  localparam int REL_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] sys_count = '0;
  logic             ctl_wr = 1'b0;
  logic [2:0]       ctl_wdata = '0;
  logic             cmp_wr = 1'b0;
  logic [CNT_W-1:0] cmp_wdata = '0;
  logic             rel_wr = 1'b0;
  logic [REL_W-1:0] rel_wdata = '0;
  logic             off_wr = 1'b0;
  logic [CNT_W-1:0] off_wdata = '0;

  logic [2:0]       ctl_rd,  p_ctl_rd;
  logic [CNT_W-1:0] cmp_rd,  p_cmp_rd;
  logic [REL_W-1:0] rel_rd,  p_rel_rd;
  logic [CNT_W-1:0] off_rd,  p_off_rd;
  logic [CNT_W-1:0] chan_count, p_chan_count;
  logic             irq, p_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr_chan #(.CNT_W(CNT_W), .REL_W(REL_W), .VIRTUAL(1'b1)) i_tmr_chan (
    .clk(clk), .rst(rst), .sys_count(sys_count), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .rel_wr(rel_wr), .rel_wdata(rel_wdata), .off_wr(off_wr),
    .off_wdata(off_wdata), .ctl_rd(ctl_rd), .cmp_rd(cmp_rd), .rel_rd(rel_rd),
    .off_rd(off_rd), .chan_count(chan_count), .irq(irq)
  );

  tmr_chan #(.CNT_W(CNT_W), .REL_W(REL_W), .VIRTUAL(1'b0)) i_tmr_chan_phys (
    .clk(clk), .rst(rst), .sys_count(sys_count), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .rel_wr(rel_wr), .rel_wdata(rel_wdata), .off_wr(off_wr),
    .off_wdata(off_wdata), .ctl_rd(p_ctl_rd), .cmp_rd(p_cmp_rd),
    .rel_rd(p_rel_rd), .off_rd(p_off_rd), .chan_count(p_chan_count), .irq(p_irq)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [2:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; tick(); ctl_wr = 1'b0;
  endtask

  task automatic wr_cmp(input logic [63:0] d);
    cmp_wr = 1'b1; cmp_wdata = d; tick(); cmp_wr = 1'b0;
  endtask

  task automatic wr_rel(input logic [31:0] d);
    rel_wr = 1'b1; rel_wdata = d; tick(); rel_wr = 1'b0;
  endtask

  task automatic wr_off(input logic [63:0] d);
    off_wr = 1'b1; off_wdata = d; tick(); off_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 enable", 64'(ctl_rd[0]), 0);
    chk("R1 mask", 64'(ctl_rd[1]), 0);
    chk("R1 cmp", cmp_rd, 0);
    chk("R1 off", off_rd, 0);
    chk("R1 irq", 64'(irq), 0);
  endtask

  task automatic t_offset;
    sys_count = 64'd1000;
    wr_off(64'd300);
    chk("R2 off_rd", off_rd, 300);
    chk("R2 chan_count", chan_count, 700);
    chk("R2 phys offset ignored", p_off_rd, 0);
    chk("R2 phys count", p_chan_count, 1000);
  endtask

  task automatic t_abs_status;
    wr_cmp(64'd800);
    chk("R4 cmp", cmp_rd, 800);
    chk("R3 below", 64'(ctl_rd[2]), 0);
    sys_count = 64'd1100;
    #1;
    chk("R3 equal", 64'(ctl_rd[2]), 1);
    chk("R6 zero", 64'(rel_rd), 0);
    sys_count = 64'd1000;
    #1;
    chk("R6 positive", 64'(rel_rd), 100);
    sys_count = 64'd1200;
    #1;
    chk("R6 negative wrap", 64'(rel_rd), 64'hFFFF_FF9C);
    chk("R3 above", 64'(ctl_rd[2]), 1);
  endtask

  task automatic t_rel_write;
    wr_rel(32'hFFFF_FFCE);
    chk("R5 negative sext", cmp_rd, 850);
    wr_rel(32'h7FFF_FFFF);
    chk("R5 positive max", cmp_rd, 64'd900 + 64'h7FFF_FFFF);
    cmp_wr = 1'b1; cmp_wdata = 64'd5000;
    rel_wr = 1'b1; rel_wdata = 32'd10;
    tick();
    cmp_wr = 1'b0; rel_wr = 1'b0;
    chk("R5 abs wins", cmp_rd, 5000);
  endtask

  task automatic t_ctl_bits;
    wr_ctl(3'b111);
    chk("R7 enable", 64'(ctl_rd[0]), 1);
    chk("R7 mask", 64'(ctl_rd[1]), 1);
    chk("R7 status write ignored", 64'(ctl_rd[2]), 0);
    tick();
    chk("R8 irq masked", 64'(irq), 0);
    wr_ctl(3'b000);
  endtask

  task automatic t_irq_rules;
    cmp_wr = 1'b1; cmp_wdata = 64'd500;
    ctl_wr = 1'b1; ctl_wdata = 3'b001;
    tick();
    cmp_wr = 1'b0; ctl_wr = 1'b0;
    chk("R8 one cycle latency", 64'(irq), 0);
    tick();
    chk("R8 raised", 64'(irq), 1);
    wr_ctl(3'b011);
    chk("R9 mask still high", 64'(irq), 1);
    tick();
    chk("R9 mask drops", 64'(irq), 0);
    wr_ctl(3'b001);
    tick();
    chk("R9 unmask raises", 64'(irq), 1);
    wr_ctl(3'b000);
    tick();
    chk("R9 disable drops", 64'(irq), 0);
    wr_ctl(3'b001);
    tick();
    chk("R9 enable raises", 64'(irq), 1);
  endtask

  task automatic t_reeval;
    wr_cmp(64'd2000);
    tick();
    chk("R10 cmp write drops", 64'(irq), 0);
    sys_count = 64'd2300;
    tick();
    chk("R10 count reaches", 64'(irq), 1);
    wr_off(64'd400);
    tick();
    chk("R10 offset write drops", 64'(irq), 0);
    wr_rel(32'd0);
    chk("R5 rel zero", cmp_rd, 1900);
    tick();
    chk("R10 rel write raises", 64'(irq), 1);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick();
    t_reset();
    t_offset();
    t_abs_status();
    t_rel_write();
    t_ctl_bits();
    t_irq_rules();
    t_reeval();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule